// File: doc/BRIEF.md
# Delay Line Unit Calibrator

This block is a hardware sequencer that finds the right per-cell delay unit for a tapped delay line. The line is a chain of eleven delay cells. Its per-cell delay is set by a 7-bit unit code. Once the unit is right, one clock period spans part of the chain but not all of it. A start pulse launches a sweep over the unit code, from the smallest value upward. For each code the sequencer turns on the line and its sampler, then programs the code together with the top phase select. It waits a bounded number of cycles for the line to report a valid length pattern, and then judges that pattern.

The first code whose 12-bit length pattern is non-zero and has its top bit clear is taken as the result. The sequencer also reports the highest usable phase, which is the bit index of the pattern's most significant set bit. A code whose pattern never becomes valid within the wait window is skipped, not treated as fatal. If no code up to 127 qualifies, the block raises both done and fail. The delay line itself sits outside the block, behind a small programming and read-back port.

Top module: `dlu_calibrator`

## Requirements
- R1: Within one sweep the unit codes are written to the line starting at 0 and rising by exactly one per step. There is one write per step and no code above 127.
- R2: Every write carries the phase select value 12, which is one past the 11-cell chain.
- R3: The line enable and the sampler enable are both high in the cycle before each write and during it.
- R4: After a write, the length-valid flag is sampled on each of the next WAIT_CYCLES (default 16) rising clock edges. If it is seen high on one of them, its pattern is judged. Otherwise the sweep moves on to the next unit code without stopping.
- R5: A pattern is accepted only if it is greater than 0 and less than 2048 (bit 11 clear). The values 0 and 2048 to 4095 are rejected and the sweep continues.
- R6: On acceptance, cal_unit shows the accepted unit code and cal_max_phase shows the index of the highest set bit of the pattern (bit 0 is the least significant), and done rises with fail low.
- R7: If no code from 0 to 127 is accepted, done and fail both rise after 128 writes.
- R8: A start pulse while no sweep runs clears done and fail on the next edge and begins a sweep. Done stays high until the next start. A start during a sweep is ignored.
- R9: cal_unit and cal_max_phase change only when a sweep ends with acceptance. They keep their values during a sweep and after a failed sweep.
- R10: After reset, done, fail, both enables and the write strobe are low, and cal_unit and cal_max_phase are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that launches a sweep |
| dl_en | output | 1 | Delay line enable |
| dl_sample_en | output | 1 | Length sampler enable |
| dl_cfg_wr | output | 1 | One-cycle strobe that programs unit and phase |
| dl_unit | output | 7 | Unit code being programmed |
| dl_sel | output | 4 | Phase select being programmed |
| dl_len_vld | input | 1 | Length pattern valid from the line |
| dl_len | input | 12 | Sampled length pattern |
| cal_unit | output | 7 | Last accepted unit code |
| cal_max_phase | output | 4 | Highest usable phase of the last accepted unit |
| cal_done | output | 1 | Sweep finished; held until next start |
| cal_fail | output | 1 | Sweep found no usable unit |

## Verification
The bench aims at the edges of the acceptance test. It checks that patterns of 0, exactly 2048 and all ones are passed over, and that 2047 is taken with phase 10. A judge that tested only for non-zero would stop on the wrong code. It also probes the wait window one cycle either side of its limit: a design that counts one cycle too many or too few either accepts the slow unit or skips the fast one. The bench runs a sweep where nothing qualifies and one where only code 127 does. These expose a unit counter that wraps or stops early, and a result register that is overwritten on failure. A start pulse in the middle of a sweep must leave the write order untouched.

// File: rtl/dlu_pkg.sv
// Package: shared state encoding for the delay line unit calibrator.
// Assumes: nothing beyond IEEE 1800-2017.
package dlu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ENABLE  = 3'd1,
        ST_PROGRAM = 3'd2,
        ST_WAIT    = 3'd3,
        ST_CHECK   = 3'd4
    } dlu_state_e;

endpackage

// File: rtl/dlu_wait_timer.sv
// Module: bounded wait counter for the length-valid flag.
// Counts cycles while run is high and raises expired in the last permitted
// cycle. Assumes LIMIT >= 2; clear has priority over run.
module dlu_wait_timer #(
    parameter int unsigned LIMIT = 16,
    localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);

    logic [CW-1:0] cnt_q;

    // Last permitted cycle of the window.
    assign expired = run && (cnt_q == CW'(LIMIT - 1));

    // Cycle counter, restarted whenever the wait is not in progress.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (run && !expired) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // The counter never passes the end of the window (R4).
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(LIMIT));

endmodule

// File: rtl/dlu_len_judge.sv
// Module: judges a sampled length pattern.
// accept is high when the pattern is non-zero and no bit at or above CELLS
// is set. top_idx is the index of the highest set bit. Purely combinational.
module dlu_len_judge #(
    parameter int unsigned CELLS = 11,
    parameter int unsigned LEN_W = CELLS + 1,
    parameter int unsigned IDX_W = $clog2(LEN_W)
) (
    input  logic [LEN_W-1:0] len,
    output logic             accept,
    output logic [IDX_W-1:0] top_idx
);

    logic [LEN_W-1:0] is_top;

    // One-hot marker of the highest set bit, one cell per bit position.
    for (genvar g = 0; g < LEN_W; g++) begin : g_top
        if (g == LEN_W - 1) begin : g_msb
            assign is_top[g] = len[g];
        end else begin : g_lower
            assign is_top[g] = len[g] && !(|len[LEN_W-1:g+1]);
        end
    end

    // Encode the one-hot marker into a bit index.
    always_comb begin
        top_idx = '0;
        for (int i = 0; i < LEN_W; i++) begin
            if (is_top[i]) top_idx = IDX_W'(i);
        end
    end

    // Pattern lies strictly inside the chain.
    assign accept = (|len) && !(|len[LEN_W-1:CELLS]);

endmodule

// File: rtl/dlu_calibrator.sv
// Module: delay line unit calibrator (top).
// Sweeps the unit code upward from 0. For each code it enables the line and
// sampler, writes code and top phase, waits a bounded time for a length
// pattern and accepts the first pattern lying strictly inside the chain.
// Assumes the line drops dl_len_vld on each write and raises it when a fresh
// pattern is ready.
module dlu_calibrator #(
    parameter int unsigned UNIT_W      = 7,
    parameter int unsigned CELLS       = 11,
    parameter int unsigned WAIT_CYCLES = 16,
    localparam int unsigned LEN_W      = CELLS + 1,
    localparam int unsigned SEL_W      = $clog2(CELLS + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              dl_en,
    output logic              dl_sample_en,
    output logic              dl_cfg_wr,
    output logic [UNIT_W-1:0] dl_unit,
    output logic [SEL_W-1:0]  dl_sel,
    input  logic              dl_len_vld,
    input  logic [LEN_W-1:0]  dl_len,
    output logic [UNIT_W-1:0] cal_unit,
    output logic [SEL_W-1:0]  cal_max_phase,
    output logic              cal_done,
    output logic              cal_fail
);

    import dlu_pkg::*;

    localparam logic [SEL_W-1:0]  CAL_SEL   = SEL_W'(CELLS + 1);
    localparam logic [UNIT_W-1:0] UNIT_LAST = {UNIT_W{1'b1}};

    dlu_state_e        state_q;
    logic [UNIT_W-1:0] unit_q;
    logic [LEN_W-1:0]  len_q;
    logic [UNIT_W-1:0] res_unit_q;
    logic [SEL_W-1:0]  res_max_q;
    logic              done_q;
    logic              fail_q;
    logic              wait_expired;
    logic              len_ok;
    logic [SEL_W-1:0]  len_top;
    logic              last_unit;

    // Window counter for the length-valid flag.
    dlu_wait_timer #(
        .LIMIT (WAIT_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q != ST_WAIT),
        .run     ((state_q == ST_WAIT) && !dl_len_vld),
        .expired (wait_expired)
    );

    // Acceptance test and top-bit index of the captured pattern.
    dlu_len_judge #(
        .CELLS (CELLS),
        .LEN_W (LEN_W),
        .IDX_W (SEL_W)
    ) u_judge (
        .len     (len_q),
        .accept  (len_ok),
        .top_idx (len_top)
    );

    assign last_unit = (unit_q == UNIT_LAST);

    // Sweep sequencer: enable, program, wait, judge, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            unit_q     <= '0;
            len_q      <= '0;
            res_unit_q <= '0;
            res_max_q  <= '0;
            done_q     <= 1'b0;
            fail_q     <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        unit_q  <= '0;
                        done_q  <= 1'b0;
                        fail_q  <= 1'b0;
                        state_q <= ST_ENABLE;
                    end
                end
                ST_ENABLE: begin
                    state_q <= ST_PROGRAM;
                end
                ST_PROGRAM: begin
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (dl_len_vld) begin
                        len_q   <= dl_len;
                        state_q <= ST_CHECK;
                    end else if (wait_expired) begin
                        if (last_unit) begin
                            done_q  <= 1'b1;
                            fail_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            unit_q  <= unit_q + UNIT_W'(1);
                            state_q <= ST_ENABLE;
                        end
                    end
                end
                ST_CHECK: begin
                    if (len_ok) begin
                        res_unit_q <= unit_q;
                        res_max_q  <= len_top;
                        done_q     <= 1'b1;
                        state_q    <= ST_IDLE;
                    end else if (last_unit) begin
                        done_q  <= 1'b1;
                        fail_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        unit_q  <= unit_q + UNIT_W'(1);
                        state_q <= ST_ENABLE;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Line control and result outputs.
    assign dl_en         = (state_q != ST_IDLE);
    assign dl_sample_en  = (state_q != ST_IDLE);
    assign dl_cfg_wr     = (state_q == ST_PROGRAM);
    assign dl_unit       = unit_q;
    assign dl_sel        = CAL_SEL;
    assign cal_unit      = res_unit_q;
    assign cal_max_phase = res_max_q;
    assign cal_done      = done_q;
    assign cal_fail      = fail_q;

    // Unit code only restarts at zero or rises by one (R1).
    p_unit_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_unit != $past(dl_unit)) |->
            ((dl_unit == $past(dl_unit) + UNIT_W'(1)) || (dl_unit == '0)));

    // Both enables were already up in the cycle before a write (R3).
    p_enables_before_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dl_cfg_wr |-> ($past(dl_en) && $past(dl_sample_en) && dl_en && dl_sample_en));

    // An accepted result never names a phase beyond the chain (R6).
    p_max_in_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cal_done) && !cal_fail) |-> (cal_max_phase < SEL_W'(CELLS)));

    // Failure is only ever reported together with done (R7).
    p_fail_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cal_fail |-> cal_done);

    // A start from idle clears done on the next edge (R8).
    p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !dl_en) |=> !cal_done);

    // Results hold except on the edge that ends a sweep (R9).
    p_hold_results_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_en || !$past(dl_en)) |-> ($stable(cal_unit) && $stable(cal_max_phase)));

endmodule

// File: tb/test_dlu_calibrator.sv
// Bench: drives sweeps against a behavioural delay line model whose pattern
// and latency per unit code are set by each scenario.
module test_dlu_calibrator;

    localparam int TMO   = 16;
    localparam int NUNIT = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dl_en, dl_sample_en, dl_cfg_wr;
    logic [6:0]  dl_unit;
    logic [3:0]  dl_sel;
    logic        dl_len_vld;
    logic [11:0] dl_len;
    logic [6:0]  cal_unit;
    logic [3:0]  cal_max_phase;
    logic        cal_done, cal_fail;

    int checks = 0;
    int failures = 0;

    // Scenario tables for the line model.
    logic [11:0] pat [NUNIT];
    int          lat [NUNIT];

    // Line model state and write monitor.
    logic [6:0]  cur_unit = '0;
    int          scnt = 0;
    logic        armed = 1'b0;
    logic        vld_q = 1'b0;
    logic        prev_en = 1'b0;
    int          wr_count = 0;
    int          order_err = 0;
    int          proto_err = 0;
    int          next_exp = 0;

    always #10 clk = ~clk;

    dlu_calibrator #(.WAIT_CYCLES(TMO)) i_dlu_calibrator (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .dl_en         (dl_en),
        .dl_sample_en  (dl_sample_en),
        .dl_cfg_wr     (dl_cfg_wr),
        .dl_unit       (dl_unit),
        .dl_sel        (dl_sel),
        .dl_len_vld    (dl_len_vld),
        .dl_len        (dl_len),
        .cal_unit      (cal_unit),
        .cal_max_phase (cal_max_phase),
        .cal_done      (cal_done),
        .cal_fail      (cal_fail)
    );

    assign dl_len_vld = vld_q;
    assign dl_len     = vld_q ? pat[cur_unit] : 12'h000;

    // Behavioural delay line: drops valid on a write, raises it after lat+1 edges.
    always @(posedge clk) begin
        prev_en <= dl_en && dl_sample_en;
        if (!rst_n) begin
            vld_q <= 1'b0;
            armed <= 1'b0;
        end else begin
            if (start && !dl_en) begin
                wr_count  <= 0;
                order_err <= 0;
                proto_err <= 0;
                next_exp  <= 0;
            end
            if (dl_cfg_wr) begin
                wr_count <= wr_count + 1;
                if (int'(dl_unit) != next_exp) order_err <= order_err + 1;
                if (!(prev_en && dl_en && dl_sample_en) || dl_sel != 4'd12)
                    proto_err <= proto_err + 1;
                next_exp <= int'(dl_unit) + 1;
                cur_unit <= dl_unit;
                scnt     <= lat[dl_unit];
                vld_q    <= 1'b0;
                armed    <= 1'b1;
            end else if (armed && !vld_q) begin
                if (scnt == 0) vld_q <= 1'b1;
                else scnt <= scnt - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Index of highest set bit; -1 for zero.
    function automatic int top_bit(input logic [11:0] v);
        int r = -1;
        for (int i = 0; i < 12; i++) if (v[i]) r = i;
        return r;
    endfunction

    // First unit the requirements accept, or -1.
    function automatic int expect_unit();
        for (int u = 0; u < NUNIT; u++) begin
            if (lat[u] <= TMO - 2 && pat[u] != 12'h000 && pat[u] < 12'd2048) return u;
        end
        return -1;
    endfunction

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!cal_done && n < 8000) begin
            @(negedge clk);
            n++;
        end
        chk(cal_done, "R8 sweep finishes", int'(cal_done), 1);
    endtask

    // Full sweep with checks against the bench's own expectation.
    task automatic run_sweep(input int mid_start);
        int eu;
        int prev_u = int'(cal_unit);
        int prev_m = int'(cal_max_phase);
        eu = expect_unit();
        pulse_start();
        chk(!cal_done && !cal_fail, "R8 start clears done", int'(cal_done), 0);
        if (mid_start > 0) begin
            repeat (mid_start) @(negedge clk);
            chk(int'(cal_unit) == prev_u, "R9 unit held mid-sweep", int'(cal_unit), prev_u);
            pulse_start();
        end
        wait_done();
        chk(order_err == 0, "R1 write order", order_err, 0);
        chk(proto_err == 0, "R2 R3 write setup", proto_err, 0);
        if (eu >= 0) begin
            chk(!cal_fail, "R6 no fail", int'(cal_fail), 0);
            chk(int'(cal_unit) == eu, "R4 R5 accepted unit", int'(cal_unit), eu);
            chk(int'(cal_max_phase) == top_bit(pat[eu]), "R6 max phase",
                int'(cal_max_phase), top_bit(pat[eu]));
            chk(wr_count == eu + 1, "R1 write count", wr_count, eu + 1);
        end else begin
            chk(cal_fail, "R7 fail flag", int'(cal_fail), 1);
            chk(wr_count == NUNIT, "R7 write count", wr_count, NUNIT);
            chk(int'(cal_unit) == prev_u && int'(cal_max_phase) == prev_m,
                "R9 results kept after fail", int'(cal_unit), prev_u);
        end
        repeat (5) @(negedge clk);
        chk(cal_done, "R8 done held", int'(cal_done), 1);
    endtask

    task automatic fill(input logic [11:0] p, input int l);
        for (int u = 0; u < NUNIT; u++) begin
            pat[u] = p;
            lat[u] = l;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        fill(12'h000, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(!cal_done && !cal_fail, "R10 flags after reset", int'(cal_done), 0);
        chk(!dl_en && !dl_sample_en && !dl_cfg_wr, "R10 line idle", int'(dl_en), 0);
        chk(cal_unit == 0 && cal_max_phase == 0, "R10 results zero", int'(cal_unit), 0);

        // First unit accepted at once.
        fill(12'h001, 0);
        run_sweep(0);

        // R5 rejects 0, 2048 and all ones; 2047 accepted with phase 10.
        fill(12'h7FF, 0);
        pat[0] = 12'h000; pat[1] = 12'h800; pat[2] = 12'hFFF;
        run_sweep(0);

        // R4 window edge: one cycle too slow skipped, just in time taken.
        fill(12'h040, 0);
        lat[0] = TMO - 1;
        lat[1] = TMO - 2;
        run_sweep(0);

        // R7 nothing usable; R8 start mid-sweep ignored.
        fill(12'h000, 0);
        run_sweep(40);

        // R7 everything times out.
        fill(12'h123, TMO + 3);
        run_sweep(0);

        // R1 only the last code qualifies.
        fill(12'hC00, 1);
        pat[NUNIT-1] = 12'h001;
        run_sweep(0);

        // Random scenarios.
        for (int r = 0; r < 10; r++) begin
            int thr = $urandom_range(0, NUNIT);
            for (int u = 0; u < NUNIT; u++) begin
                lat[u] = $urandom_range(0, TMO + 2);
                if (u < thr) begin
                    case ($urandom_range(0, 2))
                        0: pat[u] = 12'h000;
                        1: pat[u] = 12'hFFF;
                        default: pat[u] = 12'h800 | 12'($urandom_range(0, 2047));
                    endcase
                end else if ($urandom_range(0, 7) == 0) begin
                    pat[u] = 12'h000;
                end else begin
                    pat[u] = 12'($urandom_range(1, 2047));
                end
            end
            run_sweep((r % 3 == 0) ? 25 : 0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule